// File: doc/BRIEF.md
# Pseudorandom Test Bit Generator (short and long PN sequences)

This block produces a pseudorandom bit stream for exercising a receiver's data capture. It can run one of two maximal-length linear feedback sequences. The short one has 9 stages, uses the polynomial x^9 + x^5 + 1 and repeats every 511 bits. The long one has 23 stages, uses x^23 + x^18 + 1 and repeats every 8,388,607 bits. Neither starts from the all-ones state that is commonly used. Each is loaded from a fixed seed: 0x0DF for the short sequence and 0x29B80A for the long one. The bit presented at the output is the complement of the conventional sequence bit.

A downstream serializer gives one advance per bit it consumes. It can group consecutive bits into serial words. A restart input returns the selected generator to its seed. Changing the short/long select reloads the seed of the generator that has just been selected. The generator that is not selected keeps its state frozen.

Top module: `pn_pattern_gen`

## Requirements
- R1: Once reset has been released and its synchronizer has settled (two clock edges), both generators hold their seeds. With the short sequence selected, `bit_out` reads 1, the complement of bit 8 of seed 0x0DF.
- R2: Define the conventional short bit stream c as follows. c[0..8] are the bits of 0x0DF, MSB first, and c[n+9] = c[n] XOR c[n+4]. Output bit n, counted from a seed load, equals NOT c[n]. Bit n is presented after n advances.
- R3: The short output stream repeats with a period of exactly 511 bits. The 511 nine-bit windows within one period are all distinct, and none of them is all ones.
- R4: Define the conventional long bit stream as follows. The first 23 bits are the bits of 0x29B80A, MSB first, and c[n+23] = c[n] XOR c[n+5]. With the long sequence selected, output bit n from a seed load equals NOT c[n].
- R5: In a cycle with `adv` low, `restart` low and no change of select, the generator state does not move, so `bit_out` holds. The generator that is not selected never moves.
- R6: A clock edge with `restart` high reloads the selected generator's seed, even when `adv` is also high. In the following cycle the output is bit 0 of that sequence.
- R7: A clock edge at which `sel_long` differs from the value it had at the previous edge reloads the seed of the newly selected generator instead of advancing it. The output stream then starts again at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_long | input | 1 | 0 selects the 511-bit sequence, 1 selects the 8,388,607-bit sequence |
| adv | input | 1 | Advance the selected generator by one bit at this edge |
| restart | input | 1 | Reload the selected generator's seed at this edge |
| bit_out | output | 1 | Current test bit (complemented sequence bit) |

## Verification
The short sequence is run for a little more than a full period from reset. This separates a correct feedback tap and seed from a wrong one, because every bit is compared with the recurrence. It also catches a truncated or non-maximal period, through the window-uniqueness sweep and the bit-for-bit repeat at 511. A 2000-bit prefix of the long sequence is compared with its own recurrence, which exposes a wrong long tap, seed or output polarity. Stalls with `adv` low, a restart that arrives together with an advance, and select changes in both directions mid-stream separate the correct reload and hold priority from variants that step when they should reload or hold.

// File: rtl/pn_pkg.sv
package pn_pkg;
  // Register length and lower feedback exponent of each sequence
  localparam int SHORT_LEN = 9;
  localparam int SHORT_TAP = 5;
  localparam int LONG_LEN  = 23;
  localparam int LONG_TAP  = 18;

  // Fixed starting states
  localparam logic [SHORT_LEN-1:0] SHORT_SEED = 9'h0DF;
  localparam logic [LONG_LEN-1:0]  LONG_SEED  = 23'h29B80A;

  typedef enum logic {
    PN_SHORT = 1'b0,
    PN_LONG  = 1'b1
  } pn_sel_e;
endpackage

// File: rtl/pn_rst_sync.sv
module pn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int               LEN  = 9,
  parameter int               TAP  = 5,
  parameter logic [LEN-1:0]   SEED = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  output logic [LEN-1:0] state
);
  localparam int MSB    = LEN - 1;
  localparam int TAP_IX = TAP - 1;

  logic [LEN-1:0] state_q;
  logic [LEN-1:0] state_d;
  logic           feedback;

  // Fibonacci form: the oldest bit leaves at the top, feedback enters at bit 0
  assign feedback = state_q[MSB] ^ state_q[TAP_IX];

  always_comb begin
    state_d = state_q;
    if (load) begin
      state_d = SEED;
    end else if (step) begin
      state_d = {state_q[MSB-1:0], feedback};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (load || step) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/pn_ctrl.sv
module pn_ctrl
  import pn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_long,
  input  logic adv,
  input  logic restart,
  output logic sel_q,
  output logic load_short,
  output logic step_short,
  output logic load_long,
  output logic step_long
);
  pn_sel_e sel_cur;
  pn_sel_e sel_prev_q;
  logic    sel_flip;
  logic    reload;

  assign sel_cur  = pn_sel_e'(sel_long);
  assign sel_flip = (sel_cur != sel_prev_q);
  assign reload   = restart | sel_flip;

  always_comb begin
    load_short = 1'b0;
    step_short = 1'b0;
    load_long  = 1'b0;
    step_long  = 1'b0;
    if (sel_cur == PN_LONG) begin
      load_long = reload;
      step_long = adv & ~reload;
    end else begin
      load_short = reload;
      step_short = adv & ~reload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q <= PN_SHORT;
    end else begin
      sel_prev_q <= sel_cur;
    end
  end

  assign sel_q = (sel_prev_q == PN_LONG);
endmodule

// File: rtl/pn_pattern_gen.sv
module pn_pattern_gen
  import pn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_long,
  input  logic adv,
  input  logic restart,
  output logic bit_out
);
  logic                 rst_n_sync;
  logic                 sel_q;
  logic                 load_short;
  logic                 step_short;
  logic                 load_long;
  logic                 step_long;
  logic [SHORT_LEN-1:0] short_state;
  logic [LONG_LEN-1:0]  long_state;
  logic                 conv_bit;

  pn_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pn_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .sel_long   (sel_long),
    .adv        (adv),
    .restart    (restart),
    .sel_q      (sel_q),
    .load_short (load_short),
    .step_short (step_short),
    .load_long  (load_long),
    .step_long  (step_long)
  );

  pn_lfsr #(.LEN(SHORT_LEN), .TAP(SHORT_TAP), .SEED(SHORT_SEED)) u_short (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load  (load_short),
    .step  (step_short),
    .state (short_state)
  );

  pn_lfsr #(.LEN(LONG_LEN), .TAP(LONG_TAP), .SEED(LONG_SEED)) u_long (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load  (load_long),
    .step  (step_long),
    .state (long_state)
  );

  assign conv_bit = sel_long ? long_state[LONG_LEN-1] : short_state[SHORT_LEN-1];
  assign bit_out  = ~conv_bit;
endmodule

// File: rtl/pn_pattern_gen_chk.sv
module pn_pattern_gen_chk
  import pn_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sel_long,
  input logic                 adv,
  input logic                 restart,
  input logic                 bit_out,
  input logic                 sel_q,
  input logic [SHORT_LEN-1:0] short_state,
  input logic [LONG_LEN-1:0]  long_state
);
  p_no_lockup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (short_state != '0) && (long_state != '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart && (sel_long == sel_q))
      |=> ((sel_long != $past(sel_long)) || $stable(bit_out)));

  p_idle_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_long && !sel_q) |=> $stable(long_state));

  p_idle_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_long && sel_q) |=> $stable(short_state));

  p_restart_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !sel_long) |=> (short_state == SHORT_SEED));

  p_restart_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && sel_long) |=> (long_state == LONG_SEED));

  p_to_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_long && !sel_q) |=> (long_state == LONG_SEED));

  p_to_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_long && sel_q) |=> (short_state == SHORT_SEED));
endmodule

bind pn_pattern_gen pn_pattern_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .sel_long    (sel_long),
  .adv         (adv),
  .restart     (restart),
  .bit_out     (bit_out),
  .sel_q       (sel_q),
  .short_state (short_state),
  .long_state  (long_state)
);

// File: tb/pn_pattern_gen_bench.sv
`timescale 1ns/1ps
module pn_pattern_gen_bench;
  logic clk;
  logic rst_n;
  logic sel_long;
  logic adv;
  logic restart;
  logic bit_out;

  int n_checks = 0;
  int n_fails  = 0;

  bit exp_s [0:599];
  bit exp_l [0:2047];
  bit got_s [0:599];
  bit seen  [0:511];

  pn_pattern_gen u_pn_pattern_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_long (sel_long),
    .adv      (adv),
    .restart  (restart),
    .bit_out  (bit_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string req, input string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // Reference streams from the recurrences in R2 and R4 (conventional, not inverted)
  initial begin
    logic [8:0]  s_seed;
    logic [22:0] l_seed;
    s_seed = 9'h0DF;
    l_seed = 23'h29B80A;
    for (int i = 0; i < 9; i++) exp_s[i] = s_seed[8-i];
    for (int i = 9; i < 600; i++) exp_s[i] = exp_s[i-9] ^ exp_s[i-5];
    for (int i = 0; i < 23; i++) exp_l[i] = l_seed[22-i];
    for (int i = 23; i < 2048; i++) exp_l[i] = exp_l[i-23] ^ exp_l[i-18];
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int uniq;
    int ones_win;
    rst_n    = 1'b0;
    sel_long = 1'b0;
    adv      = 1'b0;
    restart  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: seed state after reset
    check(bit_out, 1'b1, "R1", "short first bit after reset");

    // R2: 520 bits of the short stream from reset
    adv = 1'b1;
    for (int n = 0; n < 520; n++) begin
      got_s[n] = bit_out;
      check(bit_out, ~exp_s[n], "R2", $sformatf("short bit %0d", n));
      @(negedge clk);
    end

    // R3: exact period and distinct windows
    for (int n = 0; n < 9; n++)
      check(got_s[n+511], got_s[n], "R3", $sformatf("repeat at 511 bit %0d", n));
    for (int w = 0; w < 512; w++) seen[w] = 1'b0;
    uniq = 0;
    ones_win = 0;
    for (int n = 0; n < 511; n++) begin
      logic [8:0] win;
      for (int k = 0; k < 9; k++) win[8-k] = got_s[n+k];
      if (!seen[win]) uniq++;
      seen[win] = 1'b1;
      if (win == 9'h1FF) ones_win++;
    end
    check_int(uniq, 511, "R3", "distinct 9-bit windows in a period");
    check_int(ones_win, 0, "R3", "all-ones windows");

    // R5: stall keeps the output, then the stream resumes
    adv = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(bit_out, ~exp_s[520], "R5", $sformatf("stall cycle %0d", k));
      @(negedge clk);
    end
    adv = 1'b1;
    for (int n = 520; n < 530; n++) begin
      check(bit_out, ~exp_s[n], "R5", $sformatf("resume bit %0d", n));
      @(negedge clk);
    end

    // R6: restart wins over advance
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    for (int n = 0; n < 30; n++) begin
      check(bit_out, ~exp_s[n], "R6", $sformatf("short after restart bit %0d", n));
      @(negedge clk);
    end

    // R7 and R4: switch to long with advance held high, then a long prefix
    sel_long = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 2000; n++) begin
      check(bit_out, ~exp_l[n], "R4", $sformatf("long bit %0d", n));
      @(negedge clk);
    end

    // R6 on the long sequence
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    for (int n = 0; n < 30; n++) begin
      check(bit_out, ~exp_l[n], "R6", $sformatf("long after restart bit %0d", n));
      @(negedge clk);
    end

    // R7: back to short mid-stream restarts the short sequence
    sel_long = 1'b0;
    @(negedge clk);
    for (int n = 0; n < 20; n++) begin
      check(bit_out, ~exp_s[n], "R7", $sformatf("short after reselect bit %0d", n));
      @(negedge clk);
    end

    // R7: reselect long while stalled, long restarts at bit 0
    adv = 1'b0;
    sel_long = 1'b1;
    @(negedge clk);
    check(bit_out, ~exp_l[0], "R7", "long reselect while stalled");
    adv = 1'b1;
    for (int n = 0; n < 25; n++) begin
      check(bit_out, ~exp_l[n], "R7", $sformatf("long reselect bit %0d", n));
      @(negedge clk);
    end

    finish_run();
  end
endmodule